// File: doc/BRIEF.md
# Zero-turnaround synchronous SRAM core

A synthesizable, reduced-depth model of a single-port synchronous SRAM with 36-bit words. It is built as four 9-bit byte lanes. Each lane holds eight data bits and one parity bit. Every access takes two cycles. On a rising clock edge the core samples an address and a command. In the cycle that follows, the matching data moves. A write's data is captured on the edge that closes that data cycle. A read's data flows combinationally from the array onto the output bus. Because the command is always one cycle ahead of its data, reads and writes can alternate on every cycle with no idle bus cycle between them.

A load cycle (`adv_ld` low with the part selected) latches a new address and the read/write sense. Continuation cycles (`adv_ld` high) step a 2-bit burst counter through four words, in linear or interleaved order. They reuse the sense latched at the load. Dropping any chip enable on a load cycle stops the burst. The bus goes idle one cycle later, but a transfer already in its data cycle still completes. Holding `cen_n` high freezes the whole core, exactly as if the clock edge had not occurred.

The data path uses separate `din` and `dout` buses. `dout_vld` stands for the high-impedance state of a shared bus: while it is low, the bus is released and `dout` reads zero. All pins are plain control and data pins with no valid/ready handshake. The data cycle is fixed by the command timing, so there is nothing for back-pressure to act on. The only way to stall is `cen_n`.

Top module: `zbt_sram_core`

## Requirements
- R1: While `rst_n` is low, and after its release, the pipeline holds a deselect, so `dout_vld` is 0 and `dout` is 0. Reset acts asynchronously.
- R2: A read load on edge k (`cen_n`=0, selected, `adv_ld`=0, `rw`=1) drives `dout_vld`=1 and `dout` = the array word at that address in the cycle after edge k.
- R3: A write load on edge k stores `din` into the loaded address on edge k+1. `dout_vld` is 0 during the write's data cycle.
- R4: Writes and reads can be issued on consecutive edges in any order. A read issued on the edge that commits a write to the same address returns the new data.
- R5: Byte lane j (j = 0..3) is `din[8j+7:8j]` together with parity bit `din[32+j]`. It is written only when `bw_n[j]` is 0 in the command cycle. Any mix of lanes may be written in one cycle.
- R6: `bw_n` and `din` have no effect on read cycles, so the array word is unchanged.
- R7: On an edge with `cen_n`=1, all other synchronous inputs are ignored and every register keeps its value. `dout` and `dout_vld` stay unchanged, and no write occurs.
- R8: Selection requires `ce1_n`=0, `ce2_n`=0 and `ce2`=1. A false enable with `adv_ld`=0 ends any burst, and `dout_vld` is 0 from the next cycle on. A write already in its data cycle still commits.
- R9: With `burst_ilv`=0, continuation cycles use the low two address bits base+1, base+2, base+3 (mod 4), with the upper bits held. `rw` is ignored and the load's sense is reused.
- R10: With `burst_ilv`=1, continuation cycle n uses the low two address bits base XOR n.
- R11: `oe_n`=1 forces `dout_vld`=0 and `dout`=0 combinationally, with no clock edge needed.
- R12: An `adv_ld`=1 cycle with no burst in progress is a no-operation. `dout_vld` is 0 in the following cycle and the array is not touched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Active-low clock enable; high freezes the core |
| ce1_n | input | 1 | Active-low chip enable 1 |
| ce2_n | input | 1 | Active-low chip enable 2 |
| ce2 | input | 1 | Active-high chip enable 2 |
| adv_ld | input | 1 | 0 = load a new command, 1 = advance the burst |
| rw | input | 1 | 1 = read, 0 = write (sampled on loads only) |
| bw_n | input | 4 | Active-low byte-lane write enables |
| addr | input | ADDR_W (6) | Word address |
| burst_ilv | input | 1 | 0 = linear burst order, 1 = interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | 36 | Write data, captured at the end of the data cycle |
| dout | output | 36 | Flow-through read data, 0 when not driven |
| dout_vld | output | 1 | 1 = bus driven with read data, 0 = high impedance |

## Verification
A corrupted command stage shows on the ports in the very next data cycle. It appears either as `dout_vld` rising where the bus should be idle, or as a read returning a neighbouring word. A wrong burst counter or order shows as a wrong word on the second to fourth beat of a read burst. The bench also covers write bursts, by reading each word back individually.

Byte-mask and commit errors stay hidden in the array until a later read of that address. The vectors therefore read back every written word within a few cycles. The vectors also cover cases where a stall, a deselect or a no-operation sits between the write and its readback. A frozen edge that leaked through would show at once, as a changed `dout` during the `cen_n`-high cycle.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  // Kind of transfer held in the data-cycle stage
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

endpackage

// File: rtl/zbt_burst_seq.sv
// Burst beat address: low bits of the load address combined with the beat count.
module zbt_burst_seq #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] base_lo,
  input  logic [CNT_W-1:0] beat,
  input  logic             interleave,
  output logic [CNT_W-1:0] addr_lo
);

  always_comb begin
    if (interleave) addr_lo = base_lo ^ beat;
    else            addr_lo = base_lo + beat;
  end

endmodule

// File: rtl/zbt_ctrl.sv
// Command stage and burst state: decides what the next data cycle does.
module zbt_ctrl
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen_n,
  input  logic              sel,
  input  logic              adv_ld,
  input  logic              rw,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burst_ilv,
  output op_e               stg_op,
  output logic [ADDR_W-1:0] stg_addr,
  output logic [LANES-1:0]  stg_bw_n
);

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  beat_q;
  logic              burst_on_q;
  logic              burst_wr_q;
  logic [CNT_W-1:0]  beat_nx;
  logic [CNT_W-1:0]  lo_nx;

  assign beat_nx = beat_q + 1'b1;

  zbt_burst_seq #(.CNT_W(CNT_W)) u_seq (
    .base_lo    (base_q[CNT_W-1:0]),
    .beat       (beat_nx),
    .interleave (burst_ilv),
    .addr_lo    (lo_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_op     <= OP_IDLE;
      stg_addr   <= '0;
      stg_bw_n   <= '1;
      base_q     <= '0;
      beat_q     <= '0;
      burst_on_q <= 1'b0;
      burst_wr_q <= 1'b0;
    end else if (!cen_n) begin
      if (!adv_ld) begin
        if (sel) begin
          base_q     <= addr;
          beat_q     <= '0;
          burst_on_q <= 1'b1;
          burst_wr_q <= !rw;
          stg_op     <= rw ? OP_READ : OP_WRITE;
          stg_addr   <= addr;
          stg_bw_n   <= bw_n;
        end else begin
          burst_on_q <= 1'b0;
          stg_op     <= OP_IDLE;
        end
      end else if (burst_on_q) begin
        beat_q   <= beat_nx;
        stg_op   <= burst_wr_q ? OP_WRITE : OP_READ;
        stg_addr <= {base_q[ADDR_W-1:CNT_W], lo_nx};
        stg_bw_n <= bw_n;
      end else begin
        stg_op <= OP_IDLE;
      end
    end
  end

endmodule

// File: rtl/zbt_array.sv
// Storage with one write port masked per byte lane and a combinational read port.
module zbt_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * (LANE_W + 1),
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANES-1:0]  wlane,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam int PB = LANES * LANE_W + j;
    always_ff @(posedge clk) begin
      if (we && wlane[j]) begin
        mem[waddr][j*LANE_W +: LANE_W] <= wdata[j*LANE_W +: LANE_W];
        mem[waddr][PB]                 <= wdata[PB];
      end
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int CNT_W  = 2,
  localparam int DATA_W = LANES * (LANE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen_n,
  input  logic              ce1_n,
  input  logic              ce2_n,
  input  logic              ce2,
  input  logic              adv_ld,
  input  logic              rw,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burst_ilv,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld
);

  op_e               stg_op;
  logic [ADDR_W-1:0] stg_addr;
  logic [LANES-1:0]  stg_bw_n;
  logic [DATA_W-1:0] rdata;
  logic              sel;
  logic              commit;

  assign sel = !ce1_n && !ce2_n && ce2;

  zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cen_n     (cen_n),
    .sel       (sel),
    .adv_ld    (adv_ld),
    .rw        (rw),
    .bw_n      (bw_n),
    .addr      (addr),
    .burst_ilv (burst_ilv),
    .stg_op    (stg_op),
    .stg_addr  (stg_addr),
    .stg_bw_n  (stg_bw_n)
  );

  // The write in its data cycle commits on the edge that closes it, unless frozen
  assign commit = !cen_n && (stg_op == OP_WRITE);

  zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .we    (commit),
    .waddr (stg_addr),
    .wlane (~stg_bw_n),
    .wdata (din),
    .raddr (stg_addr),
    .rdata (rdata)
  );

  assign dout_vld = (stg_op == OP_READ) && !oe_n;
  assign dout     = dout_vld ? rdata : '0;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cen_n,
  input logic              ce1_n,
  input logic              ce2_n,
  input logic              ce2,
  input logic              adv_ld,
  input logic              rw,
  input logic              oe_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_vld
);

  logic selected;
  assign selected = !ce1_n && !ce2_n && ce2;

  // R11: output enable high always releases the bus
  p_oe_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dout_vld && dout == '0));

  // R8: a deselect load leaves the bus idle in the next cycle
  p_deselect_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld && !selected) |=> !dout_vld);

  // R2: a selected read load drives the bus in the next cycle
  p_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld && selected && rw && !oe_n) |=> (oe_n || dout_vld));

  // R3: a write's data cycle never drives the bus
  p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld && selected && !rw) |=> !dout_vld);

  // R7: a frozen edge leaves the outputs untouched
  p_freeze_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cen_n && !oe_n) |=> (oe_n || ($stable(dout_vld) && $stable(dout))));

endmodule

bind zbt_sram_core zbt_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cen_n    (cen_n),
  .ce1_n    (ce1_n),
  .ce2_n    (ce2_n),
  .ce2      (ce2),
  .adv_ld   (adv_ld),
  .rw       (rw),
  .oe_n     (oe_n),
  .dout     (dout),
  .dout_vld (dout_vld)
);

// File: tb/zbt_sram_core_tb.sv
module zbt_sram_core_tb;

  localparam int AW = 6;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cen_n = 1'b1;
  logic          ce1_n = 1'b1;
  logic          ce2_n = 1'b1;
  logic          ce2 = 1'b0;
  logic          adv_ld = 1'b0;
  logic          rw = 1'b1;
  logic [3:0]    bw_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic          burst_ilv = 1'b0;
  logic          oe_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_vld;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  zbt_sram_core u_dut (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
    .ce2(ce2), .adv_ld(adv_ld), .rw(rw), .bw_n(bw_n), .addr(addr),
    .burst_ilv(burst_ilv), .oe_n(oe_n), .din(din), .dout(dout),
    .dout_vld(dout_vld)
  );

  typedef struct packed {
    logic          cen;
    logic [2:0]    ce;    // {ce1_n, ce2_n, ce2}
    logic          adv;
    logic          rw;
    logic          ilv;
    logic [3:0]    bw;
    logic [AW-1:0] ad;
    logic [DW-1:0] d;
    logic          ev;
    logic [DW-1:0] ed;
    logic [3:0]    req;
  } vec_t;

  localparam logic [2:0] SL = 3'b001;
  localparam logic [2:0] D1 = 3'b101;
  localparam logic [2:0] D2 = 3'b000;
  localparam logic [DW-1:0] VA = 36'h3_1357_9BDF;
  localparam logic [DW-1:0] VB = 36'h5_2468_ACE0;
  localparam logic [DW-1:0] VC = 36'hF_0F0F_0F0F;
  localparam logic [DW-1:0] P1 = 36'h1_2345_6789;
  localparam logic [DW-1:0] P2 = 36'hE_DCBA_9876;
  localparam logic [DW-1:0] PM = 36'h0_2345_6776;
  localparam logic [DW-1:0] W0 = 36'h8_0000_0001;
  localparam logic [DW-1:0] W1 = 36'h4_0000_0002;
  localparam logic [DW-1:0] W2 = 36'h2_0000_0004;
  localparam logic [DW-1:0] W3 = 36'h1_0000_0008;
  localparam logic [DW-1:0] JK = 36'h7_DEAD_BEEF;

  // Row i is applied before edge i; outputs are checked just after edge i.
  localparam int NV = 32;
  localparam vec_t TBL [NV] = '{
    '{1'b0, SL, 1'b0, 1'b0, 1'b0, 4'h0, 6'h04, JK, 1'b0, 36'h0, 4'd3},  // R3 load write 4
    '{1'b0, SL, 1'b0, 1'b0, 1'b0, 4'h0, 6'h05, VA, 1'b0, 36'h0, 4'd3},  // R3 data for 4
    '{1'b0, SL, 1'b0, 1'b1, 1'b0, 4'hF, 6'h04, VB, 1'b1, VA,    4'd2},  // R2 R4 read after write
    '{1'b0, SL, 1'b0, 1'b0, 1'b0, 4'h0, 6'h06, JK, 1'b0, 36'h0, 4'd4},  // R4 write after read
    '{1'b0, SL, 1'b0, 1'b1, 1'b0, 4'hF, 6'h05, VC, 1'b1, VB,    4'd4},
    '{1'b0, SL, 1'b0, 1'b1, 1'b0, 4'hF, 6'h06, JK, 1'b1, VC,    4'd4},
    '{1'b0, D1, 1'b0, 1'b1, 1'b0, 4'hF, 6'h00, JK, 1'b0, 36'h0, 4'd8},  // R8 deselect
    '{1'b0, SL, 1'b0, 1'b0, 1'b0, 4'h0, 6'h08, JK, 1'b0, 36'h0, 4'd5},
    '{1'b0, SL, 1'b0, 1'b0, 1'b0, 4'hE, 6'h08, P1, 1'b0, 36'h0, 4'd5},  // R5 lane 0 only
    '{1'b0, SL, 1'b0, 1'b1, 1'b0, 4'h0, 6'h08, P2, 1'b1, PM,    4'd5},
    '{1'b0, SL, 1'b0, 1'b1, 1'b0, 4'h0, 6'h08, JK, 1'b1, PM,    4'd6},  // R6 bw ignored on read
    '{1'b0, SL, 1'b0, 1'b0, 1'b0, 4'h0, 6'h12, JK, 1'b0, 36'h0, 4'd9},  // R9 linear write burst
    '{1'b0, SL, 1'b1, 1'b1, 1'b0, 4'h0, 6'h00, W0, 1'b0, 36'h0, 4'd9},
    '{1'b0, SL, 1'b1, 1'b1, 1'b0, 4'h0, 6'h00, W1, 1'b0, 36'h0, 4'd9},
    '{1'b0, SL, 1'b1, 1'b1, 1'b0, 4'h0, 6'h00, W2, 1'b0, 36'h0, 4'd9},
    '{1'b0, D2, 1'b0, 1'b1, 1'b0, 4'h0, 6'h00, W3, 1'b0, 36'h0, 4'd8},  // R8 pending write completes
    '{1'b0, SL, 1'b0, 1'b1, 1'b0, 4'hF, 6'h10, JK, 1'b1, W2,    4'd9},
    '{1'b0, SL, 1'b0, 1'b1, 1'b0, 4'hF, 6'h11, JK, 1'b1, W3,    4'd8},
    '{1'b0, SL, 1'b0, 1'b1, 1'b0, 4'hF, 6'h12, JK, 1'b1, W0,    4'd9},
    '{1'b0, SL, 1'b0, 1'b1, 1'b0, 4'hF, 6'h13, JK, 1'b1, W1,    4'd9},
    '{1'b0, SL, 1'b0, 1'b1, 1'b1, 4'hF, 6'h13, JK, 1'b1, W1,    4'd10}, // R10 interleaved read
    '{1'b0, SL, 1'b1, 1'b0, 1'b1, 4'h0, 6'h00, JK, 1'b1, W0,    4'd10},
    '{1'b0, SL, 1'b1, 1'b0, 1'b1, 4'h0, 6'h00, JK, 1'b1, W3,    4'd10},
    '{1'b0, SL, 1'b1, 1'b0, 1'b1, 4'h0, 6'h00, JK, 1'b1, W2,    4'd10},
    '{1'b0, D1, 1'b0, 1'b1, 1'b0, 4'hF, 6'h00, JK, 1'b0, 36'h0, 4'd8},
    '{1'b0, SL, 1'b1, 1'b0, 1'b0, 4'h0, 6'h12, JK, 1'b0, 36'h0, 4'd12}, // R12 no-op
    '{1'b0, SL, 1'b1, 1'b0, 1'b0, 4'h0, 6'h12, JK, 1'b0, 36'h0, 4'd12},
    '{1'b0, SL, 1'b0, 1'b1, 1'b0, 4'hF, 6'h12, JK, 1'b1, W0,    4'd12},
    '{1'b0, SL, 1'b0, 1'b1, 1'b0, 4'hF, 6'h10, JK, 1'b1, W2,    4'd7},  // R7 freeze
    '{1'b1, SL, 1'b0, 1'b0, 1'b0, 4'h0, 6'h10, JK, 1'b1, W2,    4'd7},
    '{1'b0, SL, 1'b0, 1'b1, 1'b0, 4'hF, 6'h11, JK, 1'b1, W3,    4'd7},
    '{1'b0, SL, 1'b0, 1'b1, 1'b0, 4'hF, 6'h10, JK, 1'b1, W2,    4'd7}
  };

  task automatic check(input string tag, input logic ev, input logic [DW-1:0] ed);
    checks++;
    if (dout_vld !== ev || dout !== ed) begin
      errors++;
      $display("FAIL %s: vld=%0b dout=%h expected vld=%0b dout=%h", tag, dout_vld, dout, ev, ed);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 during reset", 1'b0, '0);
    @(posedge clk); #2 rst_n = 1'b1;
    @(posedge clk); #2 check("R1 after reset", 1'b0, '0);

    for (int i = 0; i < NV; i++) begin
      cen_n = TBL[i].cen;
      {ce1_n, ce2_n, ce2} = TBL[i].ce;
      adv_ld = TBL[i].adv;
      rw = TBL[i].rw;
      burst_ilv = TBL[i].ilv;
      bw_n = TBL[i].bw;
      addr = TBL[i].ad;
      din = TBL[i].d;
      @(posedge clk); #2;
      check($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].ev, TBL[i].ed);
    end

    // R11: output enable acts without a clock edge (core frozen, read of 0x10 pending)
    cen_n = 1'b1;
    oe_n = 1'b1; #0.5;
    check("R11 oe high", 1'b0, '0);
    oe_n = 1'b0; #0.5;
    check("R11 oe low", 1'b1, W2);

    // R1: asynchronous reset returns to the deselect state mid-operation
    rst_n = 1'b0; #0.5;
    check("R1 async reset", 1'b0, '0);
    @(posedge clk); #2 rst_n = 1'b1;
    cen_n = 1'b0; adv_ld = 1'b1;
    @(posedge clk); #2;
    check("R1 R12 idle after reset", 1'b0, '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule